// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block turns a periodic refresh tick into refresh requests for a DRAM channel with several ranks. It keeps a count of refreshes each rank is owed. It offers one rank at a time to a command arbiter over a request/grant pair. The arbiter grants a request by raising `refGnt` while `refReq` is high.

There are two rank modes. In group mode, every rank in turn, from the lowest number to the highest, receives one refresh for each owed tick. In independent mode, each rank is owed and served on its own.

Two enable inputs control the refresh path. One lets owed refreshes build up while the block is not allowed to issue them. The other lets it issue them, and issue also waits until DRAM initialization is marked complete.

The block also handles two kinds of calibration:
- An impedance-calibration (rcomp) request is held back by a programmable number of ticks when ranks refresh independently. In group mode it is released at once.
- When enabled, a ZQ calibration request is raised once every fixed number of ticks. It is only shown to the arbiter when no refresh is being requested.

Top module: `refresh_sched`

## Requirements
- R1: A synchronous active-low reset loads each rank's owed count from `cfgInitDebt`. It also clears the group pointer and the ZQ and rcomp state. With refresh issue disabled, `refReq`, `zqReq` and `rcompGo` are low after reset. Once issue is enabled, exactly `cfgInitDebt` refreshes per rank are requested.
- R2: With `cfgRefreshOn`=0 and `cfgAccumOn`=0, no refresh is requested and ticks add nothing to the owed counts.
- R3: With `cfgRefreshOn`=0 and `cfgAccumOn`=1, no refresh is requested, but each tick adds one owed refresh to every rank. These refreshes are issued later, once issue is enabled.
- R4: With `cfgRefreshOn`=1, ticks are counted whatever the value of `cfgAccumOn`. `refReq` is only raised while `cfgInitDone`=1.
- R5: In group mode (`cfgIndepRanks`=0), requests go to ranks 0, 1, …, NUM_RANKS-1 in that order, one rank per grant. Every rank's owed count drops by one only when the last rank is granted.
- R6: In independent mode (`cfgIndepRanks`=1), `refRank` is the lowest-numbered rank with a non-zero owed count, and a grant lowers only that rank's count.
- R7: An owed count stops at DEBT_MAX (8) and never wraps.
- R8: When a tick and a grant that lowers a count fall in the same cycle, that count is left unchanged.
- R9: With `cfgZqOn`=1, a ZQ request becomes pending on every ZQ_PERIOD-th (128th) tick. It is cleared by `zqGnt` while `zqReq` is high, and it is cleared when `cfgZqOn`=0. `zqReq` is the pending flag masked by `refReq`.
- R10: In group mode, an rcomp request taken while none is pending makes `rcompGo` high for exactly one cycle, in the cycle that follows it.
- R11: In independent mode, an accepted rcomp request waits for a number of ticks that depends on `rcompSel`: 0 selects `cfgDirectQuiet`, 1 selects `cfgIndirectQuiet`, and 2 or 3 select `cfgRcompWait`. `rcompGo` then pulses for one cycle. Requests that arrive while one is pending are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| refreshTick | input | 1 | One-cycle refresh interval event |
| cfgRefreshOn | input | 1 | Allow refresh issue |
| cfgAccumOn | input | 1 | Count ticks while issue is off |
| cfgIndepRanks | input | 1 | 0 = group mode, 1 = independent ranks |
| cfgZqOn | input | 1 | Enable periodic ZQ requests |
| cfgInitDone | input | 1 | DRAM initialization complete |
| cfgInitDebt | input | 3 | Owed count loaded at reset |
| cfgDirectQuiet | input | 6 | Tick window for rcompSel 0 |
| cfgIndirectQuiet | input | 6 | Tick window for rcompSel 1 |
| cfgRcompWait | input | 5 | Tick window for rcompSel 2 and 3 |
| rcompReq | input | 1 | Rcomp service request |
| rcompSel | input | 2 | Window selector for the request |
| rcompGo | output | 1 | Rcomp may be serviced now |
| refReq | output | 1 | Refresh request to arbiter |
| refRank | output | 2 | Rank the refresh is for |
| refGnt | input | 1 | Arbiter grant for refresh |
| zqReq | output | 1 | ZQ calibration request |
| zqGnt | input | 1 | Arbiter grant for ZQ |

## Verification
Several events can land on a single clock edge, and the bench is built to make them do so:
- A tick and a refresh grant can hit the same edge. The bench drives ticks every cycle while the arbiter grants on every request, so an add and a subtract meet at the same owed count, including when that count is already at its cap.
- A ZQ period can run out while a refresh request is up. The bench lets ticks build owed refreshes over the ZQ wrap. The per-cycle model then decides whether `zqReq` must stay masked, and whether a grant and a new period in one cycle leave the request pending.

Every output is compared against the behavioural model on every cycle.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic debtInc;   // tick counted for every rank
    logic debtDec;   // a granted refresh retires debt
    logic decAll;    // retire on every rank (group mode)
    logic zqRun;     // ZQ period counter enabled
    logic zqStep;    // ZQ period counter advances
    logic rcLoad;    // capture a new rcomp window
    logic rcTick;    // count one tick off the rcomp window
  } schedStrobe_t;

  typedef enum logic [1:0] {
    RC_DIRECT   = 2'd0,
    RC_INDIRECT = 2'd1,
    RC_WAIT     = 2'd2,
    RC_WAIT_ALT = 2'd3
  } rcKind_t;

  localparam int INIT_W = 3;
  localparam int DQ_W   = 6;
  localparam int IQ_W   = 6;
  localparam int RW_W   = 5;
  localparam int WIN_W  = 6;

endpackage

// File: rtl/refsched_dp.sv
module refsched_dp
  import refsched_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int DEBT_MAX  = 8,
  parameter int ZQ_PERIOD = 128,
  localparam int DEBT_W   = $clog2(DEBT_MAX + 1),
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  localparam int ZQ_W     = (ZQ_PERIOD > 1) ? $clog2(ZQ_PERIOD) : 1
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  schedStrobe_t                       strobe,
  input  logic [RANK_W-1:0]                  decRank,
  input  logic                               cfgIndepRanks,
  input  logic [INIT_W-1:0]                  cfgInitDebt,
  input  logic [DQ_W-1:0]                    cfgDirectQuiet,
  input  logic [IQ_W-1:0]                    cfgIndirectQuiet,
  input  logic [RW_W-1:0]                    cfgRcompWait,
  input  logic [1:0]                         rcompSel,
  output logic [NUM_RANKS-1:0][DEBT_W-1:0]   debtVec,
  output logic                               zqWrap,
  output logic                               rcZero
);

  // Owed-refresh counters, one per rank
  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
    logic [DEBT_W-1:0] cnt;
    logic [DEBT_W-1:0] cntNext;
    logic              decHere;

    assign decHere = strobe.debtDec & (strobe.decAll | (decRank == RANK_W'(r)));

    always_comb begin
      cntNext = cnt;
      unique case ({strobe.debtInc, decHere})
        2'b10:   cntNext = (cnt == DEBT_W'(DEBT_MAX)) ? cnt : cnt + 1'b1;
        2'b01:   cntNext = (cnt == '0) ? cnt : cnt - 1'b1;
        default: cntNext = cnt;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rstN) cnt <= DEBT_W'(cfgInitDebt);
      else       cnt <= cntNext;
    end

    assign debtVec[r] = cnt;
  end

  // ZQ period counter
  logic [ZQ_W-1:0] zqCnt;
  assign zqWrap = strobe.zqStep & (zqCnt == ZQ_W'(ZQ_PERIOD - 1));

  always_ff @(posedge clk) begin
    if (!rstN || !strobe.zqRun) zqCnt <= '0;
    else if (strobe.zqStep)     zqCnt <= zqWrap ? '0 : zqCnt + 1'b1;
  end

  // Rcomp quiet window
  logic [WIN_W-1:0] rcCnt;
  logic [WIN_W-1:0] rcWin;

  always_comb begin
    unique case (rcKind_t'(rcompSel))
      RC_DIRECT:   rcWin = WIN_W'(cfgDirectQuiet);
      RC_INDIRECT: rcWin = WIN_W'(cfgIndirectQuiet);
      default:     rcWin = WIN_W'(cfgRcompWait);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)                            rcCnt <= '0;
    else if (strobe.rcLoad)               rcCnt <= cfgIndepRanks ? rcWin : '0;
    else if (strobe.rcTick && !rcZero)    rcCnt <= rcCnt - 1'b1;
  end

  assign rcZero = (rcCnt == '0);

endmodule

// File: rtl/refsched_ctrl.sv
module refsched_ctrl
  import refsched_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int DEBT_MAX  = 8,
  localparam int DEBT_W   = $clog2(DEBT_MAX + 1),
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               refreshTick,
  input  logic                               cfgRefreshOn,
  input  logic                               cfgAccumOn,
  input  logic                               cfgIndepRanks,
  input  logic                               cfgZqOn,
  input  logic                               cfgInitDone,
  input  logic                               rcompReq,
  input  logic [NUM_RANKS-1:0][DEBT_W-1:0]   debtVec,
  input  logic                               zqWrap,
  input  logic                               rcZero,
  input  logic                               refGnt,
  input  logic                               zqGnt,
  output schedStrobe_t                       strobe,
  output logic [RANK_W-1:0]                  decRank,
  output logic                               refReq,
  output logic [RANK_W-1:0]                  refRank,
  output logic                               zqReq,
  output logic                               rcompGo
);

  logic              issueOn, countOn, groupOwed, anyOwed;
  logic              lastInGroup, grant;
  logic [RANK_W-1:0] lowRank, staggerPtr;
  logic              zqPend, rcPend;

  assign countOn   = cfgRefreshOn | cfgAccumOn;
  assign issueOn   = cfgRefreshOn & cfgInitDone;
  assign groupOwed = (debtVec[0] != '0);

  // Lowest-numbered rank that is owed a refresh
  always_comb begin
    anyOwed = 1'b0;
    lowRank = '0;
    for (int r = NUM_RANKS - 1; r >= 0; r--) begin
      if (debtVec[r] != '0) begin
        anyOwed = 1'b1;
        lowRank = RANK_W'(r);
      end
    end
  end

  assign refReq      = issueOn & (cfgIndepRanks ? anyOwed : groupOwed);
  assign refRank     = cfgIndepRanks ? lowRank : staggerPtr;
  assign lastInGroup = (staggerPtr == RANK_W'(NUM_RANKS - 1));
  assign grant       = refReq & refGnt;
  assign decRank     = lowRank;

  always_comb begin
    strobe         = '0;
    strobe.debtInc = refreshTick & countOn;
    strobe.debtDec = grant & (cfgIndepRanks | lastInGroup);
    strobe.decAll  = ~cfgIndepRanks;
    strobe.zqRun   = cfgZqOn;
    strobe.zqStep  = cfgZqOn & refreshTick;
    strobe.rcLoad  = rcompReq & ~rcPend;
    strobe.rcTick  = refreshTick & rcPend;
  end

  // Group-mode rank pointer
  always_ff @(posedge clk) begin
    if (!rstN || cfgIndepRanks) staggerPtr <= '0;
    else if (grant)             staggerPtr <= lastInGroup ? '0 : staggerPtr + 1'b1;
  end

  // ZQ pending flag; a fresh period wins over a grant
  always_ff @(posedge clk) begin
    if (!rstN || !cfgZqOn)  zqPend <= 1'b0;
    else if (zqWrap)        zqPend <= 1'b1;
    else if (zqReq && zqGnt) zqPend <= 1'b0;
  end

  assign zqReq = zqPend & ~refReq;

  // Rcomp hold
  assign rcompGo = rcPend & rcZero;

  always_ff @(posedge clk) begin
    if (!rstN)          rcPend <= 1'b0;
    else if (rcompGo)   rcPend <= 1'b0;
    else if (rcompReq)  rcPend <= 1'b1;
  end

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refsched_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int DEBT_MAX  = 8,
  parameter int ZQ_PERIOD = 128,
  localparam int DEBT_W   = $clog2(DEBT_MAX + 1),
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              refreshTick,
  input  logic              cfgRefreshOn,
  input  logic              cfgAccumOn,
  input  logic              cfgIndepRanks,
  input  logic              cfgZqOn,
  input  logic              cfgInitDone,
  input  logic [2:0]        cfgInitDebt,
  input  logic [5:0]        cfgDirectQuiet,
  input  logic [5:0]        cfgIndirectQuiet,
  input  logic [4:0]        cfgRcompWait,
  input  logic              rcompReq,
  input  logic [1:0]        rcompSel,
  output logic              rcompGo,
  output logic              refReq,
  output logic [RANK_W-1:0] refRank,
  input  logic              refGnt,
  output logic              zqReq,
  input  logic              zqGnt
);

  schedStrobe_t                     strobe;
  logic [RANK_W-1:0]                decRank;
  logic [NUM_RANKS-1:0][DEBT_W-1:0] debtVec;
  logic                             zqWrap, rcZero;

  refsched_ctrl #(.NUM_RANKS(NUM_RANKS), .DEBT_MAX(DEBT_MAX)) uCtrl (
    .clk(clk), .rstN(rstN), .refreshTick(refreshTick),
    .cfgRefreshOn(cfgRefreshOn), .cfgAccumOn(cfgAccumOn),
    .cfgIndepRanks(cfgIndepRanks), .cfgZqOn(cfgZqOn), .cfgInitDone(cfgInitDone),
    .rcompReq(rcompReq), .debtVec(debtVec), .zqWrap(zqWrap), .rcZero(rcZero),
    .refGnt(refGnt), .zqGnt(zqGnt), .strobe(strobe), .decRank(decRank),
    .refReq(refReq), .refRank(refRank), .zqReq(zqReq), .rcompGo(rcompGo)
  );

  refsched_dp #(.NUM_RANKS(NUM_RANKS), .DEBT_MAX(DEBT_MAX), .ZQ_PERIOD(ZQ_PERIOD)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .decRank(decRank),
    .cfgIndepRanks(cfgIndepRanks), .cfgInitDebt(cfgInitDebt),
    .cfgDirectQuiet(cfgDirectQuiet), .cfgIndirectQuiet(cfgIndirectQuiet),
    .cfgRcompWait(cfgRcompWait), .rcompSel(rcompSel),
    .debtVec(debtVec), .zqWrap(zqWrap), .rcZero(rcZero)
  );

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int NUM_RANKS = 4,
  parameter int DEBT_MAX  = 8,
  localparam int DEBT_W   = $clog2(DEBT_MAX + 1),
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input logic                             clk,
  input logic                             rstN,
  input logic                             cfgRefreshOn,
  input logic                             cfgInitDone,
  input logic                             cfgIndepRanks,
  input logic                             refReq,
  input logic [RANK_W-1:0]                refRank,
  input logic                             refGnt,
  input logic                             zqReq,
  input logic                             rcompGo,
  input logic [NUM_RANKS-1:0][DEBT_W-1:0] debtVec
);

  // R4: no refresh offered unless issue is enabled and init is done
  p_issue_gate_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgRefreshOn || !cfgInitDone) |-> !refReq);

  // R9: ZQ yields to refresh
  p_zq_yield_r9: assert property (@(posedge clk) disable iff (!rstN)
    zqReq |-> !refReq);

  // R11 / R10: rcomp release is a single-cycle pulse
  p_rcomp_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    rcompGo |=> !rcompGo);

  // R5: in group mode, a grant below the last rank moves to the next rank
  p_stagger_step_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!cfgIndepRanks && cfgRefreshOn && cfgInitDone && refReq && refGnt &&
     refRank != RANK_W'(NUM_RANKS - 1))
    |=> (!(cfgRefreshOn && cfgInitDone && !cfgIndepRanks) ||
         (refReq && refRank == RANK_W'($past(refRank) + 1'b1))));

  for (genvar r = 0; r < NUM_RANKS; r++) begin : g_chk
    // R7: owed count never exceeds its cap
    p_debt_cap_r7: assert property (@(posedge clk) disable iff (!rstN)
      debtVec[r] <= DEBT_W'(DEBT_MAX));

    // R8: owed count moves by at most one per cycle
    p_debt_step_r8: assert property (@(posedge clk) disable iff (!rstN)
      (debtVec[r] == $past(debtVec[r])) ||
      (debtVec[r] == $past(debtVec[r]) + 1'b1) ||
      (debtVec[r] + 1'b1 == $past(debtVec[r])));
  end

endmodule

bind refresh_sched refresh_sched_chk #(.NUM_RANKS(NUM_RANKS), .DEBT_MAX(DEBT_MAX)) uChk (
  .clk(clk), .rstN(rstN), .cfgRefreshOn(cfgRefreshOn), .cfgInitDone(cfgInitDone),
  .cfgIndepRanks(cfgIndepRanks), .refReq(refReq), .refRank(refRank), .refGnt(refGnt),
  .zqReq(zqReq), .rcompGo(rcompGo), .debtVec(debtVec)
);

// File: tb/refresh_sched_test.sv
`timescale 1ns/1ps
module refresh_sched_test;
  localparam int NR = 4, DMAX = 8, ZP = 128;

  logic clk = 1'b0, rstN = 1'b0;
  logic refreshTick = 0, cfgRefreshOn = 0, cfgAccumOn = 0, cfgIndepRanks = 0;
  logic cfgZqOn = 0, cfgInitDone = 0;
  logic [2:0] cfgInitDebt = 3'd3;
  logic [5:0] cfgDirectQuiet = 6'h10, cfgIndirectQuiet = 6'h18;
  logic [4:0] cfgRcompWait = 5'h06;
  logic rcompReq = 0;
  logic [1:0] rcompSel = 0;
  logic rcompGo, refReq, refGnt = 0, zqReq, zqGnt = 0;
  logic [1:0] refRank;

  refresh_sched #(.NUM_RANKS(NR), .DEBT_MAX(DMAX), .ZQ_PERIOD(ZP)) uut (
    .clk(clk), .rstN(rstN), .refreshTick(refreshTick), .cfgRefreshOn(cfgRefreshOn),
    .cfgAccumOn(cfgAccumOn), .cfgIndepRanks(cfgIndepRanks), .cfgZqOn(cfgZqOn),
    .cfgInitDone(cfgInitDone), .cfgInitDebt(cfgInitDebt), .cfgDirectQuiet(cfgDirectQuiet),
    .cfgIndirectQuiet(cfgIndirectQuiet), .cfgRcompWait(cfgRcompWait), .rcompReq(rcompReq),
    .rcompSel(rcompSel), .rcompGo(rcompGo), .refReq(refReq), .refRank(refRank),
    .refGnt(refGnt), .zqReq(zqReq), .zqGnt(zqGnt)
  );

  always #10 clk = ~clk;  // 50 MHz

  int errs = 0, checks = 0, grants = 0;
  string tag = "R1";
  bit gntOn = 0, gntAlways = 0, done = 0;
  logic [15:0] lfsr = 16'hACE1;

  // Reference model state
  int mDebt[NR];
  int mPtr = 0, mZqCnt = 0, mRcCnt = 0;
  bit mZqPend = 0, mRcPend = 0;

  task automatic check(input bit ok, input string t, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0d expected=%0d", t, what, act, exp);
    end
  endtask

  task automatic calcExp(output bit req, output int rank, output bit zq, output bit go);
    bit issue;
    issue = cfgRefreshOn && cfgInitDone;
    req = 0; rank = 0;
    if (!cfgIndepRanks) begin
      req = issue && (mDebt[0] > 0);
      rank = mPtr;
    end else begin
      for (int r = NR - 1; r >= 0; r--)
        if (mDebt[r] > 0) begin req = issue; rank = r; end
    end
    zq = mZqPend && !req;
    go = mRcPend && (mRcCnt == 0);
  endtask

  function automatic int rcWindow(input logic [1:0] s);
    if (s == 2'd0) return int'(cfgDirectQuiet);
    if (s == 2'd1) return int'(cfgIndirectQuiet);
    return int'(cfgRcompWait);
  endfunction

  // Model update at each clock edge
  always @(posedge clk) begin
    bit eReq, eZq, eGo, g, inc, wrap, dec;
    int eRank;
    calcExp(eReq, eRank, eZq, eGo);
    if (!rstN) begin
      for (int r = 0; r < NR; r++) mDebt[r] = int'(cfgInitDebt);
      mPtr = 0; mZqCnt = 0; mZqPend = 0; mRcPend = 0; mRcCnt = 0;
    end else begin
      g = eReq && refGnt;
      if (g) grants++;
      inc = refreshTick && (cfgRefreshOn || cfgAccumOn);
      for (int r = 0; r < NR; r++) begin
        dec = g && (cfgIndepRanks ? (r == eRank) : (mPtr == NR - 1));
        if (inc && !dec && mDebt[r] < DMAX) mDebt[r]++;
        else if (dec && !inc) mDebt[r]--;
      end
      if (cfgIndepRanks) mPtr = 0;
      else if (g) mPtr = (mPtr + 1) % NR;
      if (!cfgZqOn) begin
        mZqCnt = 0; mZqPend = 0;
      end else begin
        wrap = refreshTick && (mZqCnt == ZP - 1);
        if (refreshTick) mZqCnt = (mZqCnt + 1) % ZP;
        if (wrap) mZqPend = 1;
        else if (eZq && zqGnt) mZqPend = 0;
      end
      if (!mRcPend) begin
        if (rcompReq) begin
          mRcPend = 1;
          mRcCnt = cfgIndepRanks ? rcWindow(rcompSel) : 0;
        end
      end else if (mRcCnt == 0) mRcPend = 0;
      else if (refreshTick) mRcCnt--;
    end
  end

  // Compare every cycle, away from the active edge
  always @(negedge clk) begin
    bit eReq, eZq, eGo;
    int eRank;
    if (rstN && !done) begin
      calcExp(eReq, eRank, eZq, eGo);
      check(refReq === eReq, tag, "refReq", int'(refReq), int'(eReq));
      if (eReq) check(int'(refRank) == eRank, tag, "refRank", int'(refRank), eRank);
      check(zqReq === eZq, tag, "zqReq", int'(zqReq), int'(eZq));
      check(rcompGo === eGo, tag, "rcompGo", int'(rcompGo), int'(eGo));
    end
  end

  // Arbiter responder
  always @(negedge clk) begin
    #2;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    refGnt = refReq && gntOn && (gntAlways || lfsr[0]);
    zqGnt  = zqReq && lfsr[5];
  end

  task automatic runCycles(input int n, input int tickEvery, input int rcEvery);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      refreshTick = (tickEvery > 0) && (i % tickEvery == 0);
      rcompReq = (rcEvery > 0) && (i % rcEvery == 0);
      if (rcEvery > 0) rcompSel = 2'((i / rcEvery) % 4);
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    check(0, "WDOG", "timeout", 0, 1);
    finishRun();
  end

  initial begin
    repeat (4) @(negedge clk);
    #1 rstN = 1;
    @(negedge clk); #5;
    // R1: reset state with issue disabled
    check(refReq == 0, "R1", "reset refReq", int'(refReq), 0);
    check(zqReq == 0, "R1", "reset zqReq", int'(zqReq), 0);
    check(rcompGo == 0, "R1", "reset rcompGo", int'(rcompGo), 0);

    // R4: init not done blocks issue
    tag = "R4"; gntOn = 1; gntAlways = 1; cfgRefreshOn = 1;
    runCycles(10, 0, 0);
    check(grants == 0, "R4", "grants before init", grants, 0);
    // R1: initial debt of 3 per rank
    tag = "R1"; grants = 0; cfgInitDone = 1;
    runCycles(30, 0, 0);
    check(grants == 12, "R1", "initial grants", grants, 12);

    // R2: both enables off
    tag = "R2"; cfgRefreshOn = 0;
    runCycles(20, 4, 0);
    grants = 0; cfgRefreshOn = 1;
    runCycles(20, 0, 0);
    check(grants == 0, "R2", "grants after idle ticks", grants, 0);

    // R3: accumulate while issue off
    tag = "R3"; cfgRefreshOn = 0; cfgAccumOn = 1;
    runCycles(20, 4, 0);
    grants = 0; cfgRefreshOn = 1; cfgAccumOn = 0;
    runCycles(40, 0, 0);
    check(grants == 20, "R3", "accumulated grants", grants, 20);

    // R7: saturation at 8
    tag = "R7"; cfgRefreshOn = 0; cfgAccumOn = 1;
    runCycles(24, 2, 0);
    grants = 0; cfgRefreshOn = 1;
    runCycles(50, 0, 0);
    check(grants == 32, "R7", "saturated grants", grants, 32);

    // R5: group order with irregular grants; R8: tick meets grant
    tag = "R5"; gntAlways = 0;
    runCycles(160, 7, 0);
    tag = "R8"; gntAlways = 1;
    runCycles(60, 1, 0);
    tag = "R5";
    runCycles(60, 0, 0);

    // R6: independent ranks
    tag = "R6"; cfgIndepRanks = 1; gntAlways = 0;
    runCycles(200, 5, 0);
    gntAlways = 1;
    runCycles(80, 0, 0);

    // R9: ZQ with refresh overlap, then idle refresh, then disable
    tag = "R9"; cfgIndepRanks = 0; cfgZqOn = 1;
    runCycles(1100, 8, 0);
    cfgRefreshOn = 0; cfgAccumOn = 0;
    runCycles(1100, 1, 0);
    cfgZqOn = 0;
    runCycles(20, 1, 0);

    // R10: group mode rcomp release
    tag = "R10";
    runCycles(40, 3, 5);

    // R11: independent mode windows
    tag = "R11"; cfgIndepRanks = 1;
    cfgDirectQuiet = 6'd3; cfgIndirectQuiet = 6'd5; cfgRcompWait = 5'd2;
    runCycles(240, 2, 3);
    runCycles(20, 0, 0);

    finishRun();
  end

endmodule